// File: doc/BRIEF.md
# General-Purpose I/O Bank with Pin Interrupts

This block is one bank of 32 general-purpose pins behind a word-addressed register port. Software sets each pin's direction and output value, reads back the synchronised input level, and sets the pad bias and the drive-strength code for the pin. Every pin also has an interrupt detector. It can sense a level, a single edge or both edges. The detector latches a status bit that software clears by writing ones. All unmasked status bits are combined into one registered interrupt line.

A parameter fixes the bank's base address. Only accesses whose upper address bits match that base are decoded, so several banks can share one register port at a stride of 0x200 bytes. Pin n uses bit n of every per-pin register. The register port is a plain control path with no back-pressure. A read presented in one cycle returns its data on `reg_rdata` in the next cycle. A write takes effect at the clock edge that samples it.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero. `pin_out`, `pin_oe`, `pull_up`, `pull_dn`, `drive_code`, `irq_out` and `reg_rdata` are all low.
- R2: Offset 0x04 holds the output value and offset 0x08 the output enable (1 = drive). Both read back as written and appear directly on `pin_out` and `pin_oe`.
- R3: A read of offset 0x00 returns the pin levels after a two-flop synchroniser, whatever the output enable holds.
- R4: In edge mode (bit at 0x0C = 0) with the dual bit at 0x10 clear, the polarity bit at 0x14 latches status on a rising transition when 1 and on a falling transition when 0. The opposite transition latches nothing.
- R5: In edge mode with the dual bit at 0x10 set, both transitions latch status.
- R6: In level mode (bit at 0x0C = 1), status is set on every cycle the synchronised pin equals the polarity bit at 0x14. A clear therefore does not remove it while the level stays active.
- R7: Offset 0x1C reads the raw latched status. Offset 0x20 reads raw status AND the mask at 0x18, where mask 1 enables the pin.
- R8: Writing 1 to a bit at 0x24 clears that status bit and writing 0 leaves it. 0x24 always reads zero. A new event in the same cycle as a clear leaves the bit set.
- R9: `irq_out` is the OR of all masked status bits, delayed by one register.
- R10: With the pull-enable bit at 0x38 set, the pull-select bit at 0x34 gives pull-up when 1 and pull-down when 0. With pull-enable clear, `pull_up` and `pull_dn` are both low.
- R11: Bit i (i = 0..2) of pin n's drive code is stored at bit n of offset 0x58 + 4·i. It appears on `drive_code[3n+i]`, and the code equals mA/2 − 1.
- R12: Accesses whose address bits above bit 8 differ from the base are ignored, and their reads return zero. Unmapped offsets read zero. Writes to 0x00, 0x1C and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW (12) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NPIN (32) | Pin levels from the pads |
| pin_out | output | NPIN (32) | Output values to the pads |
| pin_oe | output | NPIN (32) | Output enables to the pads |
| pull_up | output | NPIN (32) | Pull-up resistor on |
| pull_dn | output | NPIN (32) | Pull-down resistor on |
| drive_code | output | 3·NPIN (96) | Per-pin drive code, pin n at [3n+2:3n] |
| irq_out | output | 1 | Combined interrupt |

## Verification
The status latch and the write-one-to-clear path can act on the same bit in the same clock. The bench makes this happen with a dual-edge pin whose status is already set. It toggles the pin two edges before it presents a clear write, so that the synchronised transition and the clear reach the status register together. The bit must then read back as set, and a second clear with no new event must leave it zero. Level-mode pins held active during a clear exercise the same overlap on every cycle, and the random rounds compare their status against a model that counts them as re-latched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int OFF_W    = 9;
  localparam int DATA_W   = 32;
  localparam int DRV_BITS = 3;

  localparam logic [OFF_W-1:0] OFF_DIN   = 9'h000;
  localparam logic [OFF_W-1:0] OFF_DOUT  = 9'h004;
  localparam logic [OFF_W-1:0] OFF_OE    = 9'h008;
  localparam logic [OFF_W-1:0] OFF_LEVEL = 9'h00C;
  localparam logic [OFF_W-1:0] OFF_DUAL  = 9'h010;
  localparam logic [OFF_W-1:0] OFF_POL   = 9'h014;
  localparam logic [OFF_W-1:0] OFF_MASK  = 9'h018;
  localparam logic [OFF_W-1:0] OFF_RAW   = 9'h01C;
  localparam logic [OFF_W-1:0] OFF_MSTAT = 9'h020;
  localparam logic [OFF_W-1:0] OFF_CLR   = 9'h024;
  localparam logic [OFF_W-1:0] OFF_PSEL  = 9'h034;
  localparam logic [OFF_W-1:0] OFF_PEN   = 9'h038;
  localparam logic [OFF_W-1:0] OFF_DRV0  = 9'h058;

  // One pin's detection decision for this cycle.
  function automatic logic sense_hit(input logic level, input logic dual,
                                     input logic pol, input logic now,
                                     input logic prev);
    if (level)     return now == pol;
    else if (dual) return now != prev;
    else if (pol)  return now & ~prev;
    else           return ~now & prev;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)      stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl_now,
  input  logic [NPIN-1:0] cfg_level,
  input  logic [NPIN-1:0] cfg_dual,
  input  logic [NPIN-1:0] cfg_pol,
  input  logic [NPIN-1:0] cfg_mask,
  input  logic [NPIN-1:0] clr_bits,
  output logic [NPIN-1:0] raw_status,
  output logic            irq_out
);
  logic [NPIN-1:0] lvl_prev;
  logic [NPIN-1:0] evt;
  logic [NPIN-1:0] status_q;
  logic [NPIN-1:0] lvl_hit;
  logic            irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl_now;
  end

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign evt[i] = sense_hit(cfg_level[i], cfg_dual[i], cfg_pol[i],
                                lvl_now[i], lvl_prev[i]);
    end
  endgenerate

  // A new event outranks a clear aimed at the same bit.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_bits) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_q & cfg_mask);
  end

  assign raw_status = status_q;
  assign irq_out    = irq_q;
  assign lvl_hit    = cfg_level & ~(lvl_now ^ cfg_pol);

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt)) == '0)); // R4
  AST_LEVEL_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lvl_hit) & ~status_q) == '0)); // R6
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt & clr_bits) & ~status_q) == '0)); // R8
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int               NPIN      = 32,
  parameter int               AW        = 12,
  parameter logic [AW-1:0]    BASE_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_en,
  input  logic                reg_we,
  input  logic [AW-1:0]       reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NPIN-1:0]     din_sync,
  input  logic [NPIN-1:0]     raw_status,
  output logic [NPIN-1:0]     dout,
  output logic [NPIN-1:0]     oe,
  output logic [NPIN-1:0]     cfg_level,
  output logic [NPIN-1:0]     cfg_dual,
  output logic [NPIN-1:0]     cfg_pol,
  output logic [NPIN-1:0]     cfg_mask,
  output logic [NPIN-1:0]     pull_sel,
  output logic [NPIN-1:0]     pull_en,
  output logic [NPIN-1:0]     drv_slice [DRV_BITS],
  output logic [NPIN-1:0]     clr_bits
);
  logic [OFF_W-1:0]  off;
  logic              hit, wr_fire, rd_fire;
  logic [NPIN-1:0]   wbits;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign off     = reg_addr[OFF_W-1:0];
  assign hit     = reg_addr[AW-1:OFF_W] == BASE_ADDR[AW-1:OFF_W];
  assign wr_fire = reg_en & reg_we & hit;
  assign rd_fire = reg_en & ~reg_we;
  assign wbits   = reg_wdata[NPIN-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout      <= '0;
      oe        <= '0;
      cfg_level <= '0;
      cfg_dual  <= '0;
      cfg_pol   <= '0;
      cfg_mask  <= '0;
      pull_sel  <= '0;
      pull_en   <= '0;
    end else if (wr_fire) begin
      case (off)
        OFF_DOUT:  dout      <= wbits;
        OFF_OE:    oe        <= wbits;
        OFF_LEVEL: cfg_level <= wbits;
        OFF_DUAL:  cfg_dual  <= wbits;
        OFF_POL:   cfg_pol   <= wbits;
        OFF_MASK:  cfg_mask  <= wbits;
        OFF_PSEL:  pull_sel  <= wbits;
        OFF_PEN:   pull_en   <= wbits;
        default:   ;
      endcase
    end
  end

  generate
    for (genvar b = 0; b < DRV_BITS; b++) begin : g_drv
      localparam logic [OFF_W-1:0] SLICE_OFF = OFF_DRV0 + OFF_W'(4*b);
      always_ff @(posedge clk) begin
        if (!rst_n)                          drv_slice[b] <= '0;
        else if (wr_fire && off == SLICE_OFF) drv_slice[b] <= wbits;
      end
    end
  endgenerate

  assign clr_bits = (wr_fire && off == OFF_CLR) ? wbits : '0;

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_DIN:   rd_mux = DATA_W'(din_sync);
        OFF_DOUT:  rd_mux = DATA_W'(dout);
        OFF_OE:    rd_mux = DATA_W'(oe);
        OFF_LEVEL: rd_mux = DATA_W'(cfg_level);
        OFF_DUAL:  rd_mux = DATA_W'(cfg_dual);
        OFF_POL:   rd_mux = DATA_W'(cfg_pol);
        OFF_MASK:  rd_mux = DATA_W'(cfg_mask);
        OFF_RAW:   rd_mux = DATA_W'(raw_status);
        OFF_MSTAT: rd_mux = DATA_W'(raw_status & cfg_mask);
        OFF_PSEL:  rd_mux = DATA_W'(pull_sel);
        OFF_PEN:   rd_mux = DATA_W'(pull_en);
        default: begin
          for (int b = 0; b < DRV_BITS; b++)
            if (off == OFF_DRV0 + OFF_W'(4*b)) rd_mux = DATA_W'(drv_slice[b]);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && off == OFF_CLR) |=> (reg_rdata == '0)); // R8
  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && off == OFF_OE) |=> $stable(oe)); // R2
  AST_FOREIGN_BANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !hit) |=> ($stable(dout) && $stable(cfg_mask))); // R12
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int            NPIN      = 32,
  parameter int            AW        = 12,
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_en,
  input  logic                     reg_we,
  input  logic [AW-1:0]            reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NPIN-1:0]          pin_in,
  output logic [NPIN-1:0]          pin_out,
  output logic [NPIN-1:0]          pin_oe,
  output logic [NPIN-1:0]          pull_up,
  output logic [NPIN-1:0]          pull_dn,
  output logic [DRV_BITS*NPIN-1:0] drive_code,
  output logic                     irq_out
);
  logic [NPIN-1:0] din_sync, raw_status, clr_bits;
  logic [NPIN-1:0] cfg_level, cfg_dual, cfg_pol, cfg_mask;
  logic [NPIN-1:0] pull_sel, pull_en;
  logic [NPIN-1:0] drv_slice [DRV_BITS];

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_sync)
  );

  gpio_regfile #(.NPIN(NPIN), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .din_sync(din_sync), .raw_status(raw_status),
    .dout(pin_out), .oe(pin_oe),
    .cfg_level(cfg_level), .cfg_dual(cfg_dual), .cfg_pol(cfg_pol),
    .cfg_mask(cfg_mask), .pull_sel(pull_sel), .pull_en(pull_en),
    .drv_slice(drv_slice), .clr_bits(clr_bits)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_now(din_sync),
    .cfg_level(cfg_level), .cfg_dual(cfg_dual), .cfg_pol(cfg_pol),
    .cfg_mask(cfg_mask), .clr_bits(clr_bits),
    .raw_status(raw_status), .irq_out(irq_out)
  );

  assign pull_up = pull_en & pull_sel;
  assign pull_dn = pull_en & ~pull_sel;

  generate
    for (genvar n = 0; n < NPIN; n++) begin : g_pad
      for (genvar b = 0; b < DRV_BITS; b++) begin : g_bit
        assign drive_code[DRV_BITS*n + b] = drv_slice[b][n];
      end
    end
  endgenerate

  AST_IRQ_TRACKS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(raw_status & cfg_mask)))); // R9
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0); // R10
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  localparam int NPIN = 32;
  localparam int AW   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_en = 1'b0;
  logic              reg_we = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NPIN-1:0]   pin_in = '0;
  logic [NPIN-1:0]   pin_out, pin_oe, pull_up, pull_dn;
  logic [3*NPIN-1:0] drive_code;
  logic              irq_out;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  gpio_bank #(.NPIN(NPIN), .AW(AW), .BASE_ADDR(12'h000)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .drive_code(drive_code),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic hit_fn(input logic lvl, input logic dual, input logic pol,
                                  input logic prev, input logic now);
    if (lvl)       return now == pol;
    else if (dual) return now != prev;
    else if (pol)  return !prev && now;
    else           return prev && !now;
  endfunction

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    cyc(3);
    @(negedge clk) rst_n = 1'b1;
    cyc(1);

    // R1: reset state
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
    chk("R1 drive_code", drive_code[31:0], 0);
    rd(12'h01C, d); chk("R1 raw status", d, 0);
    rd(12'h018, d); chk("R1 mask", d, 0);

    // R2: output path
    wr(12'h004, 32'hA5A5_0F0F);
    wr(12'h008, 32'hFFFF_0000);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(12'h008, d); chk("R2 oe readback", d, 32'hFFFF_0000);

    // R3: input read independent of direction
    pin_in = 32'h1234_5678;
    cyc(3);
    rd(12'h000, d); chk("R3 input level", d, 32'h1234_5678);
    pin_in = '0; cyc(4);
    wr(12'h024, 32'hFFFF_FFFF);

    // R10: pull control
    wr(12'h034, 32'h0000_00F0);
    wr(12'h038, 32'h0000_0F3C);
    chk("R10 pull_up", pull_up, 32'h0000_0030);
    chk("R10 pull_dn", pull_dn, 32'h0000_0F0C);

    // R11: pin 5 code 3'b101 (12 mA)
    wr(12'h058, 32'h20);
    wr(12'h05C, 32'h00);
    wr(12'h060, 32'h20);
    chk("R11 pin5 code", {29'b0, drive_code[17:15]}, 32'd5);
    chk("R11 pin4 code", {29'b0, drive_code[14:12]}, 32'd0);
    rd(12'h060, d); chk("R11 slice2 readback", d, 32'h20);

    // R12: other bank, unmapped, read-only writes
    wr(12'h204, 32'h0);
    chk("R12 foreign write ignored", pin_out, 32'hA5A5_0F0F);
    rd(12'h204, d); chk("R12 foreign read zero", d, 0);
    rd(12'h02C, d); chk("R12 unmapped read zero", d, 0);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, d); chk("R12 raw status not writable", d, 0);

    // R4: pin 1 rising, pin 2 falling
    wr(12'h014, 32'h2);
    wr(12'h018, 32'h6);
    pin_in = 32'h6; cyc(5);
    rd(12'h01C, d); chk("R4 rising latched / falling idle", d, 32'h2);
    chk("R9 irq high", {31'b0, irq_out}, 1);
    pin_in = 32'h0; cyc(5);
    rd(12'h01C, d); chk("R4 falling latched", d, 32'h6);

    // R8: clear 0 no effect, clear 1 works, reads zero
    wr(12'h024, 32'h0);
    rd(12'h01C, d); chk("R8 write zero keeps status", d, 32'h6);
    rd(12'h024, d); chk("R8 clear reads zero", d, 0);
    wr(12'h024, 32'h6);
    rd(12'h01C, d); chk("R8 clear removes status", d, 0);
    cyc(1);
    chk("R9 irq low after clear", {31'b0, irq_out}, 0);

    // R5 and R8 collision: pin 0 dual edge
    wr(12'h010, 32'h1);
    pin_in = 32'h1; cyc(5);
    rd(12'h01C, d); chk("R5 dual rising", d, 32'h1);
    @(negedge clk) pin_in = 32'h0;
    @(posedge clk); @(posedge clk);
    wr(12'h024, 32'h1);
    rd(12'h01C, d); chk("R8 event wins over clear", d, 32'h1);
    wr(12'h024, 32'h1);
    rd(12'h01C, d); chk("R8 later clear", d, 0);

    // R6: pin 3 level high held through a clear
    wr(12'h00C, 32'h8);
    wr(12'h014, 32'h8);
    pin_in = 32'h8; cyc(5);
    wr(12'h024, 32'h8);
    rd(12'h01C, d); chk("R6 level re-latches", d, 32'h8);
    pin_in = 32'h0; cyc(4);
    wr(12'h024, 32'h8);
    rd(12'h01C, d); chk("R6 clear after inactive", d, 0);

    // Random rounds: R4 R5 R6 R7 R9
    for (int it = 0; it < 25; it++) begin
      logic [31:0] lv, du, po, mk, p0, p1, ex;
      lv = $urandom; du = $urandom; po = $urandom; mk = $urandom;
      p0 = $urandom; p1 = $urandom;
      wr(12'h00C, lv); wr(12'h010, du); wr(12'h014, po); wr(12'h018, mk);
      pin_in = p0; cyc(6);
      wr(12'h024, 32'hFFFF_FFFF);
      cyc(2);
      pin_in = p1; cyc(6);
      for (int i = 0; i < 32; i++)
        ex[i] = lv[i] ? (hit_fn(1'b1, 1'b0, po[i], 1'b0, p0[i]) |
                         hit_fn(1'b1, 1'b0, po[i], 1'b0, p1[i]))
                      : hit_fn(1'b0, du[i], po[i], p0[i], p1[i]);
      rd(12'h01C, d); chk("R4 R5 R6 random raw status", d, ex);
      rd(12'h020, d); chk("R7 random masked status", d, ex & mk);
      rd(12'h000, d); chk("R3 random input", d, p1);
      chk("R9 random irq", {31'b0, irq_out}, {31'b0, |(ex & mk)});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule